// File: doc/BRIEF.md
# Free-Running Timer Counter with Prescaler and Split-Counter Test Mode

This block is a 16-bit free-running timer counter. A programmable prescaler divides the clock by a power of two, and the counter advances by one on each prescaler tick. When the count wraps, it raises a sticky overflow flag, which software clears by writing a one. A global enable input gates all counting, so the timer can be frozen.

An 8-bit test register holds a single mode bit called bypass. When bypass is set, the prescaler is skipped. The counter then becomes two independent 8-bit halves that each advance on every enabled clock. No carry passes from the low half into the high half. In this mode the overflow flag follows only the wrap of the high half. Production tests use this mode to exercise both counter bytes and the flag logic in a few hundred cycles instead of tens of thousands.

Top module: `tmr_cnt_top`

## Requirements
- R1: While reset is high and on the first cycle after it, count reads 0x0000, the overflow flag reads 0 and the test register reads 0x00.
- R2: With bypass clear and the prescale select at n (0..7), count increments by one every 2^n enabled clocks as a single 16-bit value.
- R3: A cycle in which the prescale select differs from its value on the previous clock restarts the prescaler: no tick occurs on that cycle, and the next tick comes 2^n enabled clocks later.
- R4: While the enable input is low, count and the prescaler phase hold their values.
- R5: Writing the test register stores only bit 1, the bypass bit. The register reads back {6'b0, bypass, 1'b0}, and all other bits read 0.
- R6: With bypass set and enable high, count[7:0] and count[15:8] each increment by one on every clock, and a wrap of the low half does not carry into the high half.
- R7: With bypass clear, the overflow flag sets on the clock where the count wraps from 0xFFFF to 0x0000.
- R8: With bypass set, the overflow flag sets on the clock where count[15:8] wraps from 0xFF to 0x00, and a low-half wrap alone does not set it.
- R9: A one-cycle pulse on the flag-clear input clears the flag. If a set condition occurs on the same clock, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_en | input | 1 | Global timer enable |
| psc_sel | input | 3 | Prescale select n; divide by 2^n |
| tst_wr | input | 1 | Write strobe for the test register |
| tst_wdata | input | 8 | Test register write data (bit 1 = bypass) |
| tst_rdata | output | 8 | Test register read value |
| ovf_clr | input | 1 | Write-one-to-clear strobe for the overflow flag |
| count | output | 16 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
All three results are registered, so each one is due exactly one clock edge after the stimulus that causes it. This covers the count step after a tick or bypass clock, the flag set or clear after a wrap or clear pulse, and the new bypass readback after a test-register write. The bench drives inputs on the falling edge. A behavioural model advances on the rising edge from those same inputs, and count, flag and readback are compared against the model on the next falling edge. Every check therefore lands one edge after its cause. The set-versus-clear collision is aligned by firing the clear pulse on the falling edge where the model shows the high half at 0xFF in bypass.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W       = 16;
    localparam int HALF_W      = CNT_W / 2;
    localparam int PSC_SEL_W   = 3;
    localparam int PSC_W       = (1 << PSC_SEL_W) - 1;
    localparam int TST_W       = 8;
    localparam int TST_BYP_BIT = 1;
    localparam logic [TST_W-1:0] TST_MASK = TST_W'(1) << TST_BYP_BIT;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } cnt_halves_t;

    // Low-order ones mask selecting 2^sel prescaler phases.
    function automatic logic [PSC_W-1:0] psc_mask(input logic [PSC_SEL_W-1:0] sel);
        logic [PSC_W:0] one_hot;
        one_hot = (PSC_W+1)'(1) << sel;
        return PSC_W'(one_hot - 1'b1);
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [PSC_SEL_W-1:0] sel,
    output logic                 tick
);
    logic [PSC_W-1:0]     pcnt;
    logic [PSC_SEL_W-1:0] sel_q;
    logic                 sel_chg;
    logic [PSC_W-1:0]     mask;

    assign sel_chg = (sel != sel_q);
    assign mask    = psc_mask(sel);
    assign tick    = en && !sel_chg && ((pcnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt  <= '0;
            sel_q <= '0;
        end else begin
            sel_q <= sel;
            if (sel_chg)
                pcnt <= '0;
            else if (en)
                pcnt <= pcnt + 1'b1;
        end
    end

    // R3: a select change never produces a tick in that cycle
    a_r3_restart_no_tick: assert property (@(posedge clk) disable iff (rst)
        (sel != $past(sel)) |-> !tick);

    // R4: no tick while disabled
    a_r4_no_tick_idle: assert property (@(posedge clk) disable iff (rst)
        !en |-> !tick);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        byp,
    input  logic        tick,
    output cnt_halves_t cnt,
    output logic        wrap
);
    logic split_step;
    logic full_step;

    assign split_step = en && byp;
    assign full_step  = en && !byp && tick;
    assign wrap       = split_step ? (&cnt.hi) : (full_step && (&cnt));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (split_step) begin
            cnt.lo <= cnt.lo + 1'b1;
            cnt.hi <= cnt.hi + 1'b1;
        end else if (full_step) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: count holds while disabled
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt));

    // R6: low half steps by one each bypass clock
    a_r6_lo_step: assert property (@(posedge clk) disable iff (rst)
        (en && byp) |=> (cnt.lo == $past(cnt.lo) + 8'd1));

    // R6: high half steps by one, independent of low-half wrap
    a_r6_hi_step: assert property (@(posedge clk) disable iff (rst)
        (en && byp) |=> (cnt.hi == $past(cnt.hi) + 8'd1));

    // R2: normal mode steps by zero or one
    a_r2_unit_step: assert property (@(posedge clk) disable iff (rst)
        (en && !byp) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 16'd1));
endmodule

// File: rtl/tmr_ovf_flag.sv
module tmr_ovf_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    // R9: a set wins over a simultaneous clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);

    // R9: a lone clear empties the flag
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag);

    // R9: the flag is sticky without a clear
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);
endmodule

// File: rtl/tmr_cnt_top.sv
module tmr_cnt_top
    import tmr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tmr_en,
    input  logic [PSC_SEL_W-1:0] psc_sel,
    input  logic                 tst_wr,
    input  logic [TST_W-1:0]     tst_wdata,
    output logic [TST_W-1:0]     tst_rdata,
    input  logic                 ovf_clr,
    output logic [CNT_W-1:0]     count,
    output logic                 ovf_flag
);
    logic [TST_W-1:0] tst_q;
    logic             byp;
    logic             tick;
    logic             wrap;
    cnt_halves_t      cnt;

    always_ff @(posedge clk) begin
        if (rst)
            tst_q <= '0;
        else if (tst_wr)
            tst_q <= tst_wdata & TST_MASK;
    end

    assign byp       = tst_q[TST_BYP_BIT];
    assign tst_rdata = tst_q;
    assign count     = {cnt.hi, cnt.lo};

    tmr_prescaler u_psc (
        .clk  (clk),
        .rst  (rst),
        .en   (tmr_en),
        .sel  (psc_sel),
        .tick (tick)
    );

    tmr_counter u_cnt (
        .clk  (clk),
        .rst  (rst),
        .en   (tmr_en),
        .byp  (byp),
        .tick (tick),
        .cnt  (cnt),
        .wrap (wrap)
    );

    tmr_ovf_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .set  (wrap),
        .clr  (ovf_clr),
        .flag (ovf_flag)
    );

    // R5: written bypass bit appears in readback one edge later
    a_r5_write: assert property (@(posedge clk) disable iff (rst)
        tst_wr |=> (tst_rdata[TST_BYP_BIT] == $past(tst_wdata[TST_BYP_BIT])));

    // R7: full 16-bit wrap in normal mode raises the flag
    a_r7_normal_wrap: assert property (@(posedge clk) disable iff (rst)
        (tmr_en && !byp && tick && count == 16'hFFFF) |=> (ovf_flag && count == 16'h0000));

    // R8: high-half wrap in bypass raises the flag
    a_r8_split_wrap: assert property (@(posedge clk) disable iff (rst)
        (tmr_en && byp && count[15:8] == 8'hFF) |=> ovf_flag);
endmodule

// File: tb/tb_tmr_cnt_top.sv
module tb_tmr_cnt_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tmr_en = 1'b0;
    logic [2:0] psc_sel = 3'd0;
    logic       tst_wr = 1'b0;
    logic [7:0] tst_wdata = 8'h00;
    logic [7:0] tst_rdata;
    logic       ovf_clr = 1'b0;
    logic [15:0] count;
    logic       ovf_flag;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit live = 0;
    string tag_c = "R2";
    string tag_f = "R9";

    // behavioural reference state
    int m_cnt, m_psc, m_prev_sel, m_flag, m_byp;

    always #2 clk = ~clk;

    tmr_cnt_top dut (
        .clk(clk), .rst(rst), .tmr_en(tmr_en), .psc_sel(psc_sel),
        .tst_wr(tst_wr), .tst_wdata(tst_wdata), .tst_rdata(tst_rdata),
        .ovf_clr(ovf_clr), .count(count), .ovf_flag(ovf_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_cnt = 0; m_psc = 0; m_prev_sel = 0; m_flag = 0; m_byp = 0;
        end else begin
            bit tk;
            bit st;
            int lo;
            int hi;
            tk = 0; st = 0;
            if (psc_sel != m_prev_sel) m_psc = 0;
            else if (tmr_en) begin
                if (m_psc == (1 << psc_sel) - 1) begin tk = 1; m_psc = 0; end
                else m_psc++;
            end
            if (tmr_en) begin
                if (m_byp != 0) begin
                    lo = m_cnt % 256; hi = m_cnt / 256;
                    if (hi == 255) st = 1;
                    m_cnt = ((hi + 1) % 256) * 256 + (lo + 1) % 256;
                end else if (tk) begin
                    if (m_cnt == 65535) st = 1;
                    m_cnt = (m_cnt + 1) % 65536;
                end
            end
            if (st) m_flag = 1;
            else if (ovf_clr) m_flag = 0;
            if (tst_wr) m_byp = tst_wdata[1];
            m_prev_sel = psc_sel;
        end
    end

    always @(negedge clk) begin
        if (live) begin
            chk(tag_c, count, m_cnt);
            chk(tag_f, ovf_flag, m_flag);
            chk("R5", tst_rdata, m_byp * 2);
        end
    end

    always @(negedge clk) begin
        if (cyc > 200000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    task automatic run(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_tst(input logic [7:0] v);
        tst_wr = 1'b1; tst_wdata = v;
        @(negedge clk);
        tst_wr = 1'b0; tst_wdata = 8'h00;
    endtask

    task automatic clr_pulse();
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
    endtask

    initial begin
        run(4);
        chk("R1", count, 0);
        chk("R1", ovf_flag, 0);
        chk("R1", tst_rdata, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", count, 0);
        chk("R1", tst_rdata, 0);
        live = 1;

        tag_c = "R2"; tmr_en = 1'b1; psc_sel = 3'd0;
        run(20);
        psc_sel = 3'd2; tag_c = "R3";
        run(30);
        psc_sel = 3'd1;
        run(3);
        psc_sel = 3'd3;
        run(40);
        tag_c = "R4"; tmr_en = 1'b0;
        run(10);
        tmr_en = 1'b1;
        run(12);
        psc_sel = 3'd0; tag_c = "R2";
        run(25);

        tag_c = "R5";
        wr_tst(8'hFD);
        chk("R5", tst_rdata, 8'h00);
        wr_tst(8'hFF);
        chk("R5", tst_rdata, 8'h02);

        tag_c = "R6"; tag_f = "R8";
        run(100);
        chk("R8", ovf_flag, 0);
        run(200);
        chk("R8", ovf_flag, 1);

        tag_f = "R9";
        clr_pulse();
        chk("R9", ovf_flag, 0);
        while ((m_cnt / 256) != 255) @(negedge clk);
        clr_pulse();
        chk("R9", ovf_flag, 1);
        clr_pulse();
        chk("R9", ovf_flag, 0);

        tag_c = "R6";
        while ((m_cnt / 256) != 254) @(negedge clk);
        wr_tst(8'h00);
        tag_c = "R7"; tag_f = "R7";
        run(300);
        chk("R7", ovf_flag, 1);
        psc_sel = 3'd7; tag_c = "R2";
        run(300);

        live = 0;
        finish_run();
    end
endmodule